// File: doc/BRIEF.md
# One-Time-Programmable Fuse Memory Array

This block is a behavioural, synthesizable model of a 1024-bit memory that can be written only once. It holds 256 words of 4 bits. Every cell starts out intact and reads as 1. A burn operation clears a cell to 0, and no operation can set it back to 1. The model keeps the physical organisation of the array. Each cell sits in a 32-bit column. The upper five address bits pick one column. Within that column, the lower three address bits pick one cell out of each group of eight, and the four picked cells become the four data outputs.

A burn happens on a rising clock edge while the program-enable input is high. On that edge, exactly one of the four burn strobes must be set, and the cell it names at the current address is cleared. While programming is active, the outputs are released, because the output pins serve as burn inputs during that time.

Two extra fuse lines sit outside the user array: a test row with one cell per column, and a test column with 32 cells. Both leave the factory preset to an alternating pattern, so reading them exercises the decoders. Each is selected through its own enable input, and each can also be burned. A parameter sets the output style to either tri-state or open-drain.

Top module: `otp_fuse_array`

## Requirements
- R1: After reset, every user word reads 4'b1111.
- R2: A burn clears the addressed cell to 0, and the cell stays 0 from then on. A burn aimed at a cell that is already 0 changes nothing, and no operation ever turns a 0 into a 1.
- R3: Address bits [7:3] select column c, and address bits [2:0] select index s. Output bit g carries cell g*8+s of column c. A burn touches only that cell: every other word keeps its value.
- R4: A burn takes effect only when exactly one bit of `burn_i` is set. A strobe with two or more bits set, or with no bit set, changes nothing.
- R5: Cells change only on edges where `prog_en_i` is 1. While `prog_en_i` is 1, `data_oe_o` is 4'b0000.
- R6: When `tcol_en_i` is 1 and `trow_en_i` is 0, output bit g shows test-column cell g*8+A[2:0], whatever A[7:3] is. The factory preset is 1 for even cell indices and 0 for odd ones, so a read returns 4'b1111 when A0=0 and 4'b0000 when A0=1.
- R7: When `trow_en_i` is 1, it takes priority over `tcol_en_i`. All four outputs then show test-row cell A[7:3]. That cell's preset is 1 for an even column and 0 for an odd one.
- R8: A burn made with a test enable set clears only a test cell and leaves the user array unchanged. With the test row selected, any single strobe clears test-row cell A[7:3]. With the test column selected, strobe g clears test-column cell g*8+A[2:0].
- R9: In tri-state mode (OPEN_DRAIN=0), when `out_en_i` is 1 and `prog_en_i` is 0, `data_oe_o` is 4'b1111 and `data_o` shows the selected bits. In every other case `data_oe_o` is 4'b0000.
- R10: In open-drain mode (OPEN_DRAIN=1), `data_o` is always 0. When the outputs are enabled, `data_oe_o[g]` is 1 exactly where the selected bit is 0.
- R11: A read is combinational. A change of address or enable shows at the outputs without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for burn operations |
| rst_n | input | 1 | Asynchronous active-low reset; restores the factory state |
| addr_i | input | 8 | Word address: [7:3] selects the column, [2:0] selects the cell within each group |
| out_en_i | input | 1 | Output enable |
| prog_en_i | input | 1 | Program mode: releases the outputs and arms burning |
| burn_i | input | 4 | Burn strobe, one bit per output position |
| trow_en_i | input | 1 | Selects the test row |
| tcol_en_i | input | 1 | Selects the test column |
| data_o | output | 4 | Output data value |
| data_oe_o | output | 4 | Per-bit output drive enable |

## Verification
The assertions check three things on every clock cycle:
- no user cell ever rises from 0 to 1;
- at most one user cell changes per edge;
- nothing changes on an edge without a valid burn, and the outputs are released whenever program mode is on.

Several behaviours can only be shown by the bench's scenarios, because they depend on the address map and on the stored history. These are:
- that the right cell, and only that cell, is cleared;
- that multi-bit strobes are rejected;
- the alternating test-line presets and the priority of the test row over the test column;
- the difference between the tri-state and open-drain output styles.

The bench runs both output styles side by side against one model of the array.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [1:0] {
    REGION_USER = 2'd0,
    REGION_TROW = 2'd1,
    REGION_TCOL = 2'd2
  } otp_region_e;

endpackage

// File: rtl/otp_col_decode.sv
module otp_col_decode #(
  parameter int unsigned COL_W = 5
) (
  input  logic [COL_W-1:0]       col_addr_i,
  output logic [(1<<COL_W)-1:0]  col_sel_o
);

  localparam int unsigned NCOL = 1 << COL_W;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    assign col_sel_o[c] = (col_addr_i == COL_W'(c));
  end

endmodule

// File: rtl/otp_fuse_store.sv
module otp_fuse_store
  import otp_pkg::*;
#(
  parameter int unsigned COL_W  = 5,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned DATA_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [(1<<COL_W)-1:0]         col_sel_i,
  input  logic [SEL_W-1:0]              bit_sel_i,
  input  otp_region_e                   region_i,
  input  logic                          burn_go_i,
  input  logic [DATA_W-1:0]             burn_mask_i,
  output logic [DATA_W*(1<<SEL_W)-1:0]  col_word_o,
  output logic                          trow_bit_o
);

  localparam int unsigned NCOL     = 1 << COL_W;
  localparam int unsigned GRP      = 1 << SEL_W;
  localparam int unsigned COL_BITS = DATA_W * GRP;
  localparam logic [NCOL-1:0]     TROW_PRESET = {(NCOL/2){2'b01}};
  localparam logic [COL_BITS-1:0] TCOL_PRESET = {(COL_BITS/2){2'b01}};

  logic [COL_BITS-1:0] user_q [NCOL];
  logic [COL_BITS-1:0] user_d [NCOL];
  logic [NCOL-1:0]     trow_q, trow_d;
  logic [COL_BITS-1:0] tcol_q, tcol_d;
  logic [COL_BITS-1:0] clr_mask;

  // Per-cell clear mask: strobe g targets cell g*GRP + bit_sel
  for (genvar g = 0; g < DATA_W; g++) begin : g_grp
    for (genvar s = 0; s < GRP; s++) begin : g_cell
      assign clr_mask[g*GRP+s] = burn_mask_i[g] & (bit_sel_i == SEL_W'(s));
    end
  end

  // Next state: fuses may only go from 1 to 0
  always_comb begin
    for (int c = 0; c < NCOL; c++) begin
      user_d[c] = user_q[c];
    end
    trow_d = trow_q;
    tcol_d = tcol_q;
    if (burn_go_i) begin
      unique case (region_i)
        REGION_TROW: trow_d = trow_q & ~col_sel_i;
        REGION_TCOL: tcol_d = tcol_q & ~clr_mask;
        default: begin
          for (int c = 0; c < NCOL; c++) begin
            if (col_sel_i[c]) user_d[c] = user_q[c] & ~clr_mask;
          end
        end
      endcase
    end
  end

  // Register process with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCOL; c++) begin
        user_q[c] <= '1;
      end
      trow_q <= TROW_PRESET;
      tcol_q <= TCOL_PRESET;
    end else if (burn_go_i) begin
      for (int c = 0; c < NCOL; c++) begin
        user_q[c] <= user_d[c];
      end
      trow_q <= trow_d;
      tcol_q <= tcol_d;
    end
  end

  // Read path: AND-OR column select, then test-column override
  always_comb begin
    logic [COL_BITS-1:0] acc;
    acc = '0;
    for (int c = 0; c < NCOL; c++) begin
      acc = acc | (user_q[c] & {COL_BITS{col_sel_i[c]}});
    end
    col_word_o = (region_i == REGION_TCOL) ? tcol_q : acc;
  end

  assign trow_bit_o = |(trow_q & col_sel_i);

  for (genvar c = 0; c < NCOL; c++) begin : g_chk
    // R2: a cleared user cell never returns to 1
    a_r2_never_set: assert property (@(posedge clk) disable iff (!rst_n)
      (user_q[c] & ~$past(user_q[c])) == '0);
    // R4: at most one cell of a column changes per edge
    a_r4_single_cell: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(user_q[c] ^ $past(user_q[c])) <= 1);
    // R5: contents hold when no valid burn was requested
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !burn_go_i |=> $stable(user_q[c]));
  end

  a_r5_test_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !burn_go_i |=> ($stable(trow_q) && $stable(tcol_q)));

endmodule

// File: rtl/otp_bit_mux.sv
module otp_bit_mux
  import otp_pkg::*;
#(
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned DATA_W = 4
) (
  input  logic [DATA_W*(1<<SEL_W)-1:0] col_word_i,
  input  logic [SEL_W-1:0]             bit_sel_i,
  input  logic                         trow_bit_i,
  input  otp_region_e                  region_i,
  output logic [DATA_W-1:0]            bits_o
);

  localparam int unsigned GRP = 1 << SEL_W;

  for (genvar g = 0; g < DATA_W; g++) begin : g_mux
    logic [GRP-1:0] slice;
    assign slice     = col_word_i[g*GRP +: GRP];
    assign bits_o[g] = (region_i == REGION_TROW) ? trow_bit_i : slice[bit_sel_i];
  end

endmodule

// File: rtl/otp_pad_ctrl.sv
module otp_pad_ctrl #(
  parameter int unsigned DATA_W     = 4,
  parameter bit          OPEN_DRAIN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bits_i,
  input  logic              out_en_i,
  input  logic              prog_en_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] data_oe_o
);

  logic drive_ok;
  assign drive_ok = out_en_i & ~prog_en_i;

  if (OPEN_DRAIN) begin : g_od
    assign data_o    = '0;
    assign data_oe_o = {DATA_W{drive_ok}} & ~bits_i;
  end else begin : g_ts
    assign data_o    = bits_i;
    assign data_oe_o = {DATA_W{drive_ok}};
  end

  // R5: program mode always releases the pins
  a_r5_release_prog: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en_i |-> (data_oe_o == '0));

endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array
  import otp_pkg::*;
#(
  parameter bit OPEN_DRAIN = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] addr_i,
  input  logic       out_en_i,
  input  logic       prog_en_i,
  input  logic [3:0] burn_i,
  input  logic       trow_en_i,
  input  logic       tcol_en_i,
  output logic [3:0] data_o,
  output logic [3:0] data_oe_o
);

  localparam int unsigned SEL_W    = 3;
  localparam int unsigned DATA_W   = 4;
  localparam int unsigned COL_W    = 8 - SEL_W;
  localparam int unsigned NCOL     = 1 << COL_W;
  localparam int unsigned COL_BITS = DATA_W * (1 << SEL_W);

  logic [NCOL-1:0]     col_sel;
  logic [COL_BITS-1:0] col_word;
  logic                trow_bit;
  logic [DATA_W-1:0]   bits;
  logic                burn_single;
  logic                burn_go;
  otp_region_e         region;

  assign region = trow_en_i ? REGION_TROW :
                  tcol_en_i ? REGION_TCOL : REGION_USER;

  // Exactly one strobe bit set
  assign burn_single = (burn_i != '0) && ((burn_i & (burn_i - 4'd1)) == '0);
  assign burn_go     = prog_en_i & burn_single;

  otp_col_decode #(.COL_W(COL_W)) i_col_decode (
    .col_addr_i (addr_i[7:SEL_W]),
    .col_sel_o  (col_sel)
  );

  otp_fuse_store #(.COL_W(COL_W), .SEL_W(SEL_W), .DATA_W(DATA_W)) i_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .col_sel_i   (col_sel),
    .bit_sel_i   (addr_i[SEL_W-1:0]),
    .region_i    (region),
    .burn_go_i   (burn_go),
    .burn_mask_i (burn_i),
    .col_word_o  (col_word),
    .trow_bit_o  (trow_bit)
  );

  otp_bit_mux #(.SEL_W(SEL_W), .DATA_W(DATA_W)) i_bit_mux (
    .col_word_i (col_word),
    .bit_sel_i  (addr_i[SEL_W-1:0]),
    .trow_bit_i (trow_bit),
    .region_i   (region),
    .bits_o     (bits)
  );

  otp_pad_ctrl #(.DATA_W(DATA_W), .OPEN_DRAIN(OPEN_DRAIN)) i_pad (
    .clk       (clk),
    .rst_n     (rst_n),
    .bits_i    (bits),
    .out_en_i  (out_en_i),
    .prog_en_i (prog_en_i),
    .data_o    (data_o),
    .data_oe_o (data_oe_o)
  );

  // R4: a multi-bit strobe never counts as a burn
  a_r4_multi_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(burn_i) > 1) |-> !burn_go);

endmodule

// File: tb/test_otp_fuse_array.sv
`timescale 1ns/1ps
module test_otp_fuse_array;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] addr;
  logic       out_en, prog_en, trow_en, tcol_en;
  logic [3:0] burn;
  logic [3:0] ts_data, ts_oe, od_data, od_oe;

  int n_chk  = 0;
  int n_fail = 0;

  logic [3:0]  m_user [256];
  logic [31:0] m_trow;
  logic [31:0] m_tcol;

  always #2 clk = ~clk;

  otp_fuse_array #(.OPEN_DRAIN(1'b0)) i_otp_fuse_array (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .out_en_i(out_en),
    .prog_en_i(prog_en), .burn_i(burn), .trow_en_i(trow_en),
    .tcol_en_i(tcol_en), .data_o(ts_data), .data_oe_o(ts_oe));

  otp_fuse_array #(.OPEN_DRAIN(1'b1)) i_otp_fuse_array_od (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .out_en_i(out_en),
    .prog_en_i(prog_en), .burn_i(burn), .trow_en_i(trow_en),
    .tcol_en_i(tcol_en), .data_o(od_data), .data_oe_o(od_oe));

  // {kind[1:0], addr[7:0], burn[3:0]}; kind 0 user, 1 test row, 2 test column
  localparam int NVEC = 11;
  localparam logic [13:0] VEC [NVEC] = '{
    {2'd0, 8'h00, 4'b0001},   // R2 R3 plain burn
    {2'd0, 8'hFF, 4'b1000},   // R3 top word
    {2'd0, 8'h5A, 4'b0100},   // R2
    {2'd0, 8'h5A, 4'b0100},   // R2 repeat on a 0 cell
    {2'd0, 8'h5A, 4'b0011},   // R4 multi-bit strobe ignored
    {2'd0, 8'h5B, 4'b0000},   // R4 empty strobe
    {2'd0, 8'h08, 4'b0010},   // R3 column 1
    {2'd1, 8'h10, 4'b0001},   // R8 test row column 2
    {2'd1, 8'h18, 4'b0100},   // R8 test row already 0
    {2'd2, 8'h02, 4'b1000},   // R8 test column cell 26
    {2'd0, 8'h07, 4'b0001}    // R3 last index in column 0
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [3:0] expect_bits(input logic [1:0] kind, input logic [7:0] a);
    logic [3:0] r;
    if (kind == 2'd1) r = {4{m_trow[a[7:3]]}};
    else if (kind == 2'd2) begin
      for (int g = 0; g < 4; g++) r[g] = m_tcol[g*8 + int'(a[2:0])];
    end else r = m_user[a];
    return r;
  endfunction

  // Both output styles checked against one expected value (R9, R10)
  task automatic read_chk(input string req, input logic [1:0] kind, input logic [7:0] a);
    logic [3:0] e;
    @(negedge clk);
    addr = a; trow_en = (kind == 2'd1); tcol_en = (kind == 2'd2);
    #1;
    e = expect_bits(kind, a);
    chk({req, " R9 ts"}, {ts_oe, ts_data}, {4'hF, e});
    chk({req, " R10 od"}, {od_oe, od_data}, {~e, 4'h0});
  endtask

  task automatic do_burn(input logic [1:0] kind, input logic [7:0] a, input logic [3:0] b);
    @(negedge clk);
    addr = a; trow_en = (kind == 2'd1); tcol_en = (kind == 2'd2);
    burn = b; prog_en = 1'b1;
    #1;
    chk("R5 release in prog", {ts_oe, od_oe}, 8'h00);
    @(posedge clk);
    @(negedge clk);
    prog_en = 1'b0; burn = 4'b0000;
    if ($countones(b) == 1) begin
      if (kind == 2'd0) m_user[a] = m_user[a] & ~b;
      else if (kind == 2'd1) m_trow[a[7:3]] = 1'b0;
      else begin
        for (int g = 0; g < 4; g++) if (b[g]) m_tcol[g*8 + int'(a[2:0])] = 1'b0;
      end
    end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; addr = '0; out_en = 1'b1; prog_en = 1'b0;
    burn = '0; trow_en = 1'b0; tcol_en = 1'b0;
    for (int i = 0; i < 256; i++) m_user[i] = 4'hF;
    m_trow = {16{2'b01}};
    m_tcol = {16{2'b01}};
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 256; i++) read_chk("R1 reset", 2'd0, 8'(i));
    // R6 test column preset, independent of upper address
    for (int i = 0; i < 8; i++) begin
      read_chk("R6 tcol", 2'd2, 8'(i));
      read_chk("R6 tcol upper", 2'd2, 8'(i) | 8'hA8);
      chk("R6 pattern", {4'h0, ts_data}, {4'h0, (i % 2 == 0) ? 4'hF : 4'h0});
    end
    // R7 test row preset
    for (int c = 0; c < 32; c++) read_chk("R7 trow", 2'd1, 8'(c * 8 + 3));
    // R7 priority of test row over test column
    @(negedge clk); addr = 8'h09; trow_en = 1'b1; tcol_en = 1'b1; #1;
    chk("R7 priority", {4'h0, ts_data}, 8'h00);
    @(negedge clk); addr = 8'h10; #1;
    chk("R7 priority", {4'h0, ts_data}, 8'h0F);
    trow_en = 1'b0; tcol_en = 1'b0;

    // R5 burn strobe without program mode does nothing
    @(negedge clk); addr = 8'h33; burn = 4'b0001; trow_en = 1'b0; tcol_en = 1'b0;
    @(posedge clk); @(negedge clk); burn = 4'b0000;
    read_chk("R5 no prog", 2'd0, 8'h33);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] k; logic [7:0] a; logic [3:0] b;
      {k, a, b} = VEC[v];
      do_burn(k, a, b);
      read_chk("R2 R4 R8 after burn", k, a);
      read_chk("R3 neighbour", 2'd0, a ^ 8'h01);
      read_chk("R3 neighbour", 2'd0, a ^ 8'h08);
    end

    // R9 output disable
    @(negedge clk); out_en = 1'b0; addr = 8'h00; #1;
    chk("R9 disabled", {ts_oe, od_oe}, 8'h00);
    out_en = 1'b1;

    // R11 combinational read: no clock edge between address changes
    @(negedge clk); addr = 8'h00; #0.5;
    chk("R11 comb", {4'h0, ts_data}, {4'h0, m_user[8'h00]});
    addr = 8'hFF; #0.5;
    chk("R11 comb", {4'h0, ts_data}, {4'h0, m_user[8'hFF]});

    // R2 R3 final sweep of all words and test lines
    for (int i = 0; i < 256; i++) read_chk("R2 R3 final", 2'd0, 8'(i));
    for (int i = 0; i < 8; i++) read_chk("R8 tcol final", 2'd2, 8'(i));
    for (int c = 0; c < 32; c++) read_chk("R8 trow final", 2'd1, 8'(c * 8));

    finish_run();
  end

endmodule